// File: doc/BRIEF.md
# Sample Clock and Channel Scanner

This block is the timing and scanning core of a four-channel sampling front end. A 16-bit configuration word, written in one cycle, selects the scan pattern, the master clock period, a power-of-two divisor, the enable for each channel pair and two power-down controls. While the block runs, it produces a burst of sample strobes at the start of every scan period. Each strobe carries a channel index, in ascending order within the burst, and the sample value for that channel, taken from a stimulus bus that stands in for the converter.

The samples leave through a valid/ready stream. A sample that has been presented stays on the port with its channel and data unchanged until `out_ready` is seen high. The scan timing never waits for the consumer. A strobe that falls due while an unaccepted sample is still held is discarded, so a slow consumer loses samples but never shifts the timing grid. Leaving digital power-down starts an offset-calibration interval, shown on `cal_busy`. No strobes are produced during that interval.

Configuration fields: bits 2:0 hold the scan mode. Bits 4:3 select the master clock, with periods set by `MCLK_CYC` in system cycles, eight bits per entry and entry 0 in the low byte. An index of `NUM_CLK` or above uses the last entry. Bits 6:5 give the divisor shift. Bit 7 enables pair 0/1 and bit 8 enables pair 2/3. Bits 9 and 10 are AC-coupling flags, which are stored only. Bit 11 is analog power-down and bit 12 is digital power-down. Every master period must be at least four cycles.

Top module: `smp_scanner`

## Requirements
- R1: After reset, `out_valid` and `cal_busy` are low and the configuration is all zero, so no strobes are produced until a configuration is written.
- R2: Mode code 1cc (bits 2:0 = 4 + channel) gives one strobe per scan period, always on channel cc.
- R3: Mode code 010 gives channel 0 and then channel 1, and code 011 gives channel 2 and then channel 3, on consecutive cycles at the start of each scan period.
- R4: Mode code 001 gives channels 0, 1, 2 and 3 on four consecutive cycles at the start of each period. Mode code 000 gives no strobes.
- R5: The scan period is `MCLK_CYC[sel]` shifted left by the divisor shift, in clock cycles, where sel is bits 4:3 and the shift is bits 6:5. Every configuration write restarts the period. The first strobe is loaded at the first clock edge after the write edge.
- R6: When the enable bit of a channel's pair is clear (bit 7 for channels 0 and 1, bit 8 for channels 2 and 3), that channel's samples read as zero.
- R7: A write that clears bit 12 while bit 12 was set, and that leaves bits 11 and 12 both clear, sets `cal_busy` for `CAL_TICKS` selected master periods. No strobes are produced while `cal_busy` is high. Setting either power-down bit ends calibration at once.
- R8: While `out_valid` is high and `out_ready` is low, `out_valid`, `out_chan` and `out_data` hold. A strobe that falls due in that state is dropped.
- R9: While bit 11 or bit 12 is set, no strobes are produced and the scan period is held at its start. Clearing only the analog power-down bit does not start calibration.
- R10: `out_data` equals the `smp_in` slice `[chan*DATA_W +: DATA_W]` as sampled in the strobe cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_wdata | input | 16 | Configuration word to write |
| smp_in | input | 4*DATA_W | Current sample of each channel, channel 0 in the low slice |
| cal_busy | output | 1 | Offset calibration in progress |
| out_valid | output | 1 | Sample stream valid |
| out_ready | input | 1 | Sample stream ready |
| out_chan | output | 2 | Channel index of the presented sample |
| out_data | output | DATA_W | Presented sample value |

## Verification
The bench targets the edges of the scan grid. These are the first strobe after a configuration write, the last cycle of a calibration interval, and the burst of four strobes against a consumer that stalls in a pattern. An off-by-one in the period or calibration counters would move every strobe one cycle against the reference model. A strobe left ungated during calibration or power-down would show a sample the model does not expect. Pair grounding and the dropping of strobes under back-pressure are each checked on every cycle. A design that overwrote a held sample, or that ignored the pair enables, would show a changed channel or nonzero data.

// File: rtl/smp_scan_pkg.sv
`timescale 1ns/1ps
package smp_scan_pkg;
  localparam int NCH = 4;

  typedef struct packed {
    logic [2:0] spare;
    logic       dig_pd;
    logic       ana_pd;
    logic       ac_hi;
    logic       ac_lo;
    logic       en_hi;
    logic       en_lo;
    logic [1:0] div_shift;
    logic [1:0] clk_sel;
    logic [2:0] mode;
  } scan_cfg_t;

  typedef struct packed {
    logic [2:0] count;
    logic [1:0] base;
  } scan_pat_t;

  function automatic scan_pat_t decode_mode(input logic [2:0] mode);
    scan_pat_t p;
    if (mode[2]) begin
      p.count = 3'd1;
      p.base  = mode[1:0];
    end else begin
      case (mode[1:0])
        2'b01:   begin p.count = 3'd4; p.base = 2'd0; end
        2'b10:   begin p.count = 3'd2; p.base = 2'd0; end
        2'b11:   begin p.count = 3'd2; p.base = 2'd2; end
        default: begin p.count = 3'd0; p.base = 2'd0; end
      endcase
    end
    return p;
  endfunction
endpackage

// File: rtl/smp_scan_timer.sv
`timescale 1ns/1ps
module smp_scan_timer #(
  parameter int                 NUM_CLK   = 4,
  parameter int                 CW        = 8,
  parameter logic [4*CW-1:0]    MCLK_CYC  = {8'd5, 8'd6, 8'd7, 8'd8},
  parameter int                 CAL_TICKS = 20
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          restart,
  input  logic          halt,
  input  logic [1:0]    clk_sel,
  input  logic [1:0]    div_shift,
  input  logic          cal_start,
  input  logic          cal_stop,
  output logic [CW-1:0] slot,
  output logic          first_sub,
  output logic          cal_busy
);
  localparam int CALW = $clog2(CAL_TICKS + 1);

  logic [CW-1:0]   per_tab [4];
  logic [CW-1:0]   mlast;
  logic [2:0]      dlast;
  logic [CW-1:0]   mcnt;
  logic [2:0]      dcnt;
  logic [CALW-1:0] cal_left;
  logic            mwrap;

  for (genvar g = 0; g < 4; g++) begin : g_tab
    if (g < NUM_CLK) begin : g_have
      assign per_tab[g] = MCLK_CYC[g*CW +: CW];
    end else begin : g_clamp
      assign per_tab[g] = MCLK_CYC[(NUM_CLK-1)*CW +: CW];
    end
  end

  assign mlast = per_tab[clk_sel] - CW'(1);
  assign dlast = 3'((4'd1 << div_shift) - 4'd1);
  assign mwrap = (mcnt == mlast);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mcnt <= '0;
      dcnt <= '0;
    end else if (restart || halt) begin
      mcnt <= '0;
      dcnt <= '0;
    end else if (mwrap) begin
      mcnt <= '0;
      dcnt <= (dcnt == dlast) ? 3'd0 : dcnt + 3'd1;
    end else begin
      mcnt <= mcnt + CW'(1);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cal_left <= '0;
    end else if (cal_stop) begin
      cal_left <= '0;
    end else if (cal_start) begin
      cal_left <= CALW'(CAL_TICKS);
    end else if (cal_left != '0 && !restart && !halt && mwrap) begin
      cal_left <= cal_left - CALW'(1);
    end
  end

  assign slot      = mcnt;
  assign first_sub = (dcnt == 3'd0);
  assign cal_busy  = (cal_left != '0);
endmodule

// File: rtl/smp_scan_out.sv
`timescale 1ns/1ps
module smp_scan_out
  import smp_scan_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  strobe,
  input  logic [1:0]            chan,
  input  logic                  en_lo,
  input  logic                  en_hi,
  input  logic [NCH*DATA_W-1:0] smp_in,
  input  logic                  out_ready,
  output logic                  out_valid,
  output logic [1:0]            out_chan,
  output logic [DATA_W-1:0]     out_data
);
  logic [DATA_W-1:0] lane [NCH];

  for (genvar g = 0; g < NCH; g++) begin : g_lane
    if (g < NCH/2) begin : g_lo
      assign lane[g] = en_lo ? smp_in[g*DATA_W +: DATA_W] : '0;
    end else begin : g_hi
      assign lane[g] = en_hi ? smp_in[g*DATA_W +: DATA_W] : '0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_chan  <= '0;
      out_data  <= '0;
    end else if (strobe && (!out_valid || out_ready)) begin
      out_valid <= 1'b1;
      out_chan  <= chan;
      out_data  <= lane[chan];
    end else if (out_ready) begin
      out_valid <= 1'b0;
    end
  end
endmodule

// File: rtl/smp_scanner.sv
`timescale 1ns/1ps
module smp_scanner
  import smp_scan_pkg::*;
#(
  parameter int              DATA_W    = 16,
  parameter int              NUM_CLK   = 4,
  parameter int              CW        = 8,
  parameter logic [4*CW-1:0] MCLK_CYC  = {8'd5, 8'd6, 8'd7, 8'd8},
  parameter int              CAL_TICKS = 20
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  cfg_wr,
  input  logic [15:0]           cfg_wdata,
  input  logic [NCH*DATA_W-1:0] smp_in,
  output logic                  cal_busy,
  output logic                  out_valid,
  input  logic                  out_ready,
  output logic [1:0]            out_chan,
  output logic [DATA_W-1:0]     out_data
);
  scan_cfg_t cfg_q;
  scan_cfg_t cfg_n;
  scan_pat_t pat;
  logic      pd_now;
  logic      pd_next;
  logic      cal_go;
  logic      cal_end;
  logic [CW-1:0] slot;
  logic      first_sub;
  logic      strobe;
  logic [1:0] chan;

  assign cfg_n   = scan_cfg_t'(cfg_wdata);
  assign pd_now  = cfg_q.ana_pd | cfg_q.dig_pd;
  assign pd_next = cfg_n.ana_pd | cfg_n.dig_pd;
  assign cal_end = cfg_wr && pd_next;
  assign cal_go  = cfg_wr && cfg_q.dig_pd && !pd_next;

  always_ff @(posedge clk) begin
    if (!rst_n) cfg_q <= '0;
    else if (cfg_wr) cfg_q <= cfg_n;
  end

  assign pat = decode_mode(cfg_q.mode);

  smp_scan_timer #(
    .NUM_CLK  (NUM_CLK),
    .CW       (CW),
    .MCLK_CYC (MCLK_CYC),
    .CAL_TICKS(CAL_TICKS)
  ) u_timer (
    .clk      (clk),
    .rst_n    (rst_n),
    .restart  (cfg_wr),
    .halt     (pd_now),
    .clk_sel  (cfg_q.clk_sel),
    .div_shift(cfg_q.div_shift),
    .cal_start(cal_go),
    .cal_stop (cal_end),
    .slot     (slot),
    .first_sub(first_sub),
    .cal_busy (cal_busy)
  );

  assign strobe = !pd_now && !cal_busy && first_sub &&
                  (slot < CW'(pat.count));
  assign chan   = pat.base + slot[1:0];

  smp_scan_out #(.DATA_W(DATA_W)) u_out (
    .clk      (clk),
    .rst_n    (rst_n),
    .strobe   (strobe),
    .chan     (chan),
    .en_lo    (cfg_q.en_lo),
    .en_hi    (cfg_q.en_hi),
    .smp_in   (smp_in),
    .out_ready(out_ready),
    .out_valid(out_valid),
    .out_chan (out_chan),
    .out_data (out_data)
  );
endmodule

// File: rtl/smp_scanner_chk.sv
`timescale 1ns/1ps
module smp_scanner_chk #(
  parameter int DATA_W = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic [15:0]       cfg_bits,
  input logic              cal_busy,
  input logic              out_valid,
  input logic              out_ready,
  input logic [1:0]        out_chan,
  input logic [DATA_W-1:0] out_data
);
  AST_HOLD_STALLED: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_chan) && $stable(out_data))) // R8
    else $error("held sample changed");

  AST_QUIET_IN_PD: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && (!$past(out_valid) || $past(out_ready))) |-> !$past(cfg_bits[11] | cfg_bits[12])) // R9
    else $error("strobe during power-down");

  AST_QUIET_IN_CAL: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && (!$past(out_valid) || $past(out_ready))) |-> !$past(cal_busy)) // R7
    else $error("strobe during calibration");

  AST_CAL_NOT_IN_PD: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_bits[11] | cfg_bits[12]) |-> !cal_busy) // R7
    else $error("calibration while powered down");

  AST_GROUNDED_PAIR: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && (!$past(out_valid) || $past(out_ready)) &&
     !(out_chan[1] ? $past(cfg_bits[8]) : $past(cfg_bits[7]))) |-> (out_data == '0)) // R6
    else $error("disabled pair not grounded");

  AST_PAIR_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && (!$past(out_valid) || $past(out_ready)) && ($past(cfg_bits[2:0]) == 3'b010))
      |-> (out_chan <= 2'd1)) // R3
    else $error("pair 0/1 produced other channel");
endmodule

bind smp_scanner smp_scanner_chk #(.DATA_W(DATA_W)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .cfg_bits (cfg_q),
  .cal_busy (cal_busy),
  .out_valid(out_valid),
  .out_ready(out_ready),
  .out_chan (out_chan),
  .out_data (out_data)
);

// File: tb/smp_scanner_tb.sv
`timescale 1ns/1ps
module smp_scanner_tb;
  localparam int DW  = 16;
  localparam int CAL = 20;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          cfg_wr = 1'b0;
  logic [15:0]   cfg_wdata = '0;
  logic [4*DW-1:0] smp_in = '0;
  logic          cal_busy;
  logic          out_valid;
  logic          out_ready = 1'b1;
  logic [1:0]    out_chan;
  logic [DW-1:0] out_data;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  bit bp_on = 1'b0;
  string cur_req = "R1";

  smp_scanner #(
    .DATA_W(DW), .NUM_CLK(4), .CW(8),
    .MCLK_CYC({8'd5, 8'd6, 8'd7, 8'd8}), .CAL_TICKS(CAL)
  ) u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_wdata(cfg_wdata),
    .smp_in(smp_in), .cal_busy(cal_busy), .out_valid(out_valid),
    .out_ready(out_ready), .out_chan(out_chan), .out_data(out_data)
  );

  always #2 clk = ~clk;

  function automatic int mclk(input logic [1:0] s);
    case (s)
      2'd0: return 8;
      2'd1: return 7;
      2'd2: return 6;
      default: return 5;
    endcase
  endfunction

  // reference model state
  logic [15:0] m_cfg;
  int m_pos, m_cal, m_ch;
  bit m_ov;
  logic [DW-1:0] m_d;

  always @(posedge clk) begin : model
    int mp, per, nch, base;
    bit pd, stb, en;
    if (!rst_n) begin
      m_cfg = '0; m_pos = 0; m_cal = 0; m_ov = 0; m_ch = 0; m_d = '0;
    end else begin
      mp  = mclk(m_cfg[4:3]);
      per = mp * (1 << m_cfg[6:5]);
      pd  = m_cfg[11] | m_cfg[12];
      if (m_cfg[2]) begin nch = 1; base = m_cfg[1:0]; end
      else if (m_cfg[2:0] == 3'b001) begin nch = 4; base = 0; end
      else if (m_cfg[2:0] == 3'b010) begin nch = 2; base = 0; end
      else if (m_cfg[2:0] == 3'b011) begin nch = 2; base = 2; end
      else begin nch = 0; base = 0; end
      stb = !pd && m_cal == 0 && m_pos < nch;
      if (stb && (!m_ov || out_ready)) begin
        m_ov = 1;
        m_ch = base + m_pos;
        en = (m_ch < 2) ? m_cfg[7] : m_cfg[8];
        m_d = en ? smp_in[m_ch*DW +: DW] : '0;
      end else if (out_ready) begin
        m_ov = 0;
      end
      if (cfg_wr) begin
        if (cfg_wdata[11] | cfg_wdata[12]) m_cal = 0;
        else if (m_cfg[12]) m_cal = CAL;
        m_pos = 0;
        m_cfg = cfg_wdata;
      end else if (pd) begin
        m_pos = 0;
      end else begin
        if ((m_pos % mp) == mp - 1 && m_cal > 0) m_cal = m_cal - 1;
        m_pos = (m_pos + 1) % per;
      end
    end
  end

  // compare and drive stimulus away from the active edge
  always @(negedge clk) begin
    if (rst_n) begin
      checks++;
      if (out_valid !== m_ov) begin
        errors++;
        $display("FAIL %s: out_valid=%0b expected %0b at cycle %0d", cur_req, out_valid, m_ov, cyc);
      end else if (m_ov && (out_chan !== 2'(m_ch) || out_data !== m_d)) begin
        errors++;
        $display("FAIL %s: chan=%0d data=%h expected chan=%0d data=%h at cycle %0d",
                 cur_req, out_chan, out_data, m_ch, m_d, cyc);
      end
      if (cal_busy !== (m_cal != 0)) begin
        errors++;
        $display("FAIL %s: cal_busy=%0b expected %0b at cycle %0d", cur_req, cal_busy, (m_cal != 0), cyc);
      end
    end
    cyc++;
    for (int i = 0; i < 4; i++) smp_in[i*DW +: DW] = {cyc[11:0], 4'(i + 1)};
    out_ready = bp_on ? ((cyc % 3) != 0) : 1'b1;
  end

  task automatic wr(input logic [15:0] d);
    @(negedge clk);
    cfg_wr = 1'b1; cfg_wdata = d;
    @(negedge clk);
    cfg_wr = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin : watchdog
    #(200000 * 4);
    errors++;
    $display("FAIL watchdog: run did not end, actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin : main
    idle(3);
    rst_n = 1'b1;
    // R1: reset state, nothing until configured
    cur_req = "R1"; idle(20);
    // R7: power-up sequence then calibration interval
    cur_req = "R7";
    wr(16'h1800); idle(5);
    wr(16'h1000); idle(5);
    wr(16'h0000); idle(200);
    // R2: single channel 2, clock 1
    cur_req = "R2"; wr(16'h0180 | (16'd1 << 3) | 16'd6); idle(60);
    // R3: pair 0/1 then pair 2/3 with shift 2
    cur_req = "R3"; wr(16'h0182); idle(50);
    wr(16'h0180 | (16'd2 << 5) | (16'd2 << 3) | 16'd3); idle(80);
    // R4: all four, clock 3, shift 1; then mode 000
    cur_req = "R4"; wr(16'h0180 | (16'd1 << 5) | (16'd3 << 3) | 16'd1); idle(60);
    wr(16'h0180); idle(40);
    // R5: longest period and rewrite restarts
    cur_req = "R5"; wr(16'h0180 | (16'd3 << 5) | 16'd1); idle(30);
    wr(16'h0180 | (16'd3 << 5) | 16'd1); idle(150);
    // R6: only pair 0/1 enabled, then only pair 2/3
    cur_req = "R6"; wr(16'h0080 | (16'd3 << 3) | 16'd1); idle(40);
    wr(16'h0100 | (16'd3 << 3) | 16'd1); idle(40);
    // R8: back-pressure on four-channel bursts
    cur_req = "R8"; bp_on = 1'b1;
    wr(16'h0180 | (16'd3 << 3) | 16'd1); idle(120);
    bp_on = 1'b0; idle(5);
    // R9: analog power-down halts; clearing it starts no calibration
    cur_req = "R9"; wr(16'h0980 | 16'd1); idle(50);
    wr(16'h0180 | 16'd1); idle(60);
    // R9/R7: digital power-down mid-calibration aborts it
    wr(16'h1181); idle(10);
    wr(16'h0181); idle(30);
    wr(16'h1181); idle(10);
    wr(16'h0181); idle(200);
    // R10: data slices checked for every channel by the model
    cur_req = "R10"; wr(16'h0180 | (16'd2 << 3) | 16'd1); idle(60);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule